// File: doc/BRIEF.md
# Dual-Pointer Post-Modify Address Generator

This block forms the two operand addresses that a multiply-accumulate datapath consumes on each instruction. One address comes from an index pointer, which is one of two index registers. The other comes from a general-register pointer, which can be any of the register file's word registers. The caller passes in the current value of each pointer, a post-modify code for each pointer, and the current contents of the four offset registers. Two of those offset registers serve the index pointer and two serve the general-register pointer. A select bit per pointer kind chooses which offset of its pair applies.

On a start strobe, the block issues both addresses from the pointer values as they were before modification. It then produces the post-modified pointer values. The index result appears in the decode slot, one cycle after the strobe. The general-register result appears in the execute slot, one cycle after that.

For move-while-accumulate instructions, the block also returns a write-back address. It forms this address by applying the reverse of the index modification to the index pointer. An error output flags an index address that falls outside the internal dual-port RAM window. The general-register pointer may address the whole space and is never flagged. All address arithmetic wraps modulo 2^AW.

Top module: `agu_dual_ptr`

## Requirements
- R1: After reset, `dec_valid`, `wb_valid`, `idx_err` and `gpr_upd_valid` are 0 and every address and pointer output is 0.
- R2: One cycle after a cycle with `start` high, `dec_valid` is 1, `idx_addr` equals the `idx_ptr` value sampled with `start`, and `gpr_addr` equals the sampled `gpr_ptr` value (the access uses the value before modification).
- R3: With `dec_valid`, `idx_next` is the sampled `idx_ptr` modified by the sampled `idx_mode`. The mode codes are 0 keep, 1 add 2, 2 subtract 2, 3 add the offset, 4 subtract the offset. The offset is `qx0` when `idx_qsel` is 0 and `qx1` when it is 1. All results are taken modulo 2^16.
- R4: With `gpr_upd_valid`, `gpr_next` is the sampled `gpr_ptr` modified by the sampled `gpr_mode`. The codes are the same as in R3, and the offset is `qr0` when `gpr_qsel` is 0 and `qr1` when it is 1. All results are taken modulo 2^16.
- R5: Mode codes 5, 6 and 7 leave the pointer unchanged, the same as code 0.
- R6: `wb_valid` is 1 exactly one cycle after `start` with `pmove` high. `wb_addr` is then the index pointer modified in reverse: −2 for code 1, +2 for code 2, −offset for code 3, +offset for code 4, and unchanged otherwise.
- R7: `idx_err` is 1 together with `dec_valid` exactly when `idx_addr` lies outside [RAM_BASE, RAM_BASE+RAM_BYTES−1] (default 0xF600..0xF9FF). The general-register address never raises it.
- R8: The general-register result is due one cycle later than the index result: `gpr_upd_valid` is 1 exactly one cycle after `dec_valid`.
- R9: Without `start`, `dec_valid` drops to 0 and `idx_addr`, `gpr_addr`, `idx_next` and `wb_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for one instruction |
| pmove | input | 1 | Instruction performs a parallel move (write-back address wanted) |
| idx_ptr | input | AW | Current value of the selected index pointer |
| idx_mode | input | 3 | Post-modify code for the index pointer |
| idx_qsel | input | 1 | Chooses qx0 (0) or qx1 (1) |
| gpr_ptr | input | AW | Current value of the selected general-register pointer |
| gpr_mode | input | 3 | Post-modify code for the general-register pointer |
| gpr_qsel | input | 1 | Chooses qr0 (0) or qr1 (1) |
| qx0 | input | AW | Index offset register 0 |
| qx1 | input | AW | Index offset register 1 |
| qr0 | input | AW | General-register offset register 0 |
| qr1 | input | AW | General-register offset register 1 |
| dec_valid | output | 1 | Decode-slot results valid |
| idx_addr | output | AW | Index operand address (pre-modification) |
| gpr_addr | output | AW | General-register operand address (pre-modification) |
| idx_next | output | AW | Post-modified index pointer |
| wb_valid | output | 1 | Write-back address valid |
| wb_addr | output | AW | Parallel-move write-back address |
| idx_err | output | 1 | Index address outside the internal RAM window |
| gpr_upd_valid | output | 1 | Execute-slot general-register update valid |
| gpr_next | output | AW | Post-modified general-register pointer |

## Verification
The decode-slot results (`dec_valid`, both addresses, `idx_next`, `wb_addr`, `wb_valid`, `idx_err`) are due one clock edge after the edge that samples `start`. `gpr_next` with `gpr_upd_valid` is due one edge after that. The bench raises `start` for a single cycle on a falling edge. It checks the decode-slot outputs on the next falling edge, and the execute-slot outputs one falling edge later. At that second point, `dec_valid` must be low and the decode-slot outputs must be unchanged. The sweep covers every mode code for both pointers, both offset selects, both `pmove` values, and pointer values at the wrap and window edges.

// File: rtl/agu_pkg.sv
package agu_pkg;
   localparam int MODE_W = 3;
   localparam logic [MODE_W-1:0] PM_KEEP = 3'd0;
   localparam logic [MODE_W-1:0] PM_INC2 = 3'd1;
   localparam logic [MODE_W-1:0] PM_DEC2 = 3'd2;
   localparam logic [MODE_W-1:0] PM_ADDQ = 3'd3;
   localparam logic [MODE_W-1:0] PM_SUBQ = 3'd4;
endpackage

// File: rtl/agu_postmod.sv
module agu_postmod #(
   parameter int AW   = 16,
   parameter int STEP = 2
) (
   input  logic [AW-1:0]              ptr,
   input  logic [agu_pkg::MODE_W-1:0] mode,
   input  logic [AW-1:0]              ofs,
   output logic [AW-1:0]              fwd,
   output logic [AW-1:0]              rev
);
   import agu_pkg::*;
   localparam logic [AW-1:0] STEP_V = AW'(STEP);

   always_comb begin
      case (mode)
         PM_INC2: begin fwd = ptr + STEP_V; rev = ptr - STEP_V; end
         PM_DEC2: begin fwd = ptr - STEP_V; rev = ptr + STEP_V; end
         PM_ADDQ: begin fwd = ptr + ofs;    rev = ptr - ofs;    end
         PM_SUBQ: begin fwd = ptr - ofs;    rev = ptr + ofs;    end
         default: begin fwd = ptr;          rev = ptr;          end
      endcase
   end
endmodule

// File: rtl/agu_window.sv
module agu_window #(
   parameter int AW        = 16,
   parameter int RAM_BASE  = 'hF600,
   parameter int RAM_BYTES = 1024
) (
   input  logic [AW-1:0] addr,
   output logic          outside
);
   localparam logic [AW:0] LO = (AW+1)'(RAM_BASE);
   localparam logic [AW:0] HI = (AW+1)'(RAM_BASE + RAM_BYTES);

   generate
      if (RAM_BASE == 0 && RAM_BYTES == (1 << AW)) begin : g_full
         assign outside = 1'b0;
      end else begin : g_range
         logic [AW:0] a_ext;
         assign a_ext   = {1'b0, addr};
         assign outside = (a_ext < LO) || (a_ext >= HI);
      end
   endgenerate
endmodule

// File: rtl/agu_dual_ptr.sv
module agu_dual_ptr #(
   parameter int AW        = 16,
   parameter int STEP      = 2,
   parameter int RAM_BASE  = 'hF600,
   parameter int RAM_BYTES = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          pmove,
   input  logic [AW-1:0] idx_ptr,
   input  logic [2:0]    idx_mode,
   input  logic          idx_qsel,
   input  logic [AW-1:0] gpr_ptr,
   input  logic [2:0]    gpr_mode,
   input  logic          gpr_qsel,
   input  logic [AW-1:0] qx0,
   input  logic [AW-1:0] qx1,
   input  logic [AW-1:0] qr0,
   input  logic [AW-1:0] qr1,
   output logic          dec_valid,
   output logic [AW-1:0] idx_addr,
   output logic [AW-1:0] gpr_addr,
   output logic [AW-1:0] idx_next,
   output logic          wb_valid,
   output logic [AW-1:0] wb_addr,
   output logic          idx_err,
   output logic          gpr_upd_valid,
   output logic [AW-1:0] gpr_next
);
   initial begin
      assert (AW >= 4) else $error("agu_dual_ptr: AW too small");
      assert (RAM_BYTES > 0) else $error("agu_dual_ptr: empty RAM window");
      assert (RAM_BASE + RAM_BYTES <= (1 << AW))
         else $error("agu_dual_ptr: RAM window beyond address space");
      assert (STEP > 0 && STEP < (1 << AW)) else $error("agu_dual_ptr: bad STEP");
   end

   logic [AW-1:0] qx_sel, qr_sel;
   logic [AW-1:0] idx_fwd, idx_rev, gpr_fwd, gpr_rev_unused;
   logic          out_of_win;
   logic [AW-1:0] gpr_nx_d;

   assign qx_sel = idx_qsel ? qx1 : qx0;
   assign qr_sel = gpr_qsel ? qr1 : qr0;

   agu_postmod #(.AW(AW), .STEP(STEP)) u_idx_mod (
      .ptr(idx_ptr), .mode(idx_mode), .ofs(qx_sel),
      .fwd(idx_fwd), .rev(idx_rev)
   );

   agu_postmod #(.AW(AW), .STEP(STEP)) u_gpr_mod (
      .ptr(gpr_ptr), .mode(gpr_mode), .ofs(qr_sel),
      .fwd(gpr_fwd), .rev(gpr_rev_unused)
   );

   agu_window #(.AW(AW), .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)) u_win (
      .addr(idx_ptr), .outside(out_of_win)
   );

   // decode slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         wb_valid  <= 1'b0;
         idx_err   <= 1'b0;
         idx_addr  <= '0;
         gpr_addr  <= '0;
         idx_next  <= '0;
         wb_addr   <= '0;
         gpr_nx_d  <= '0;
      end else begin
         dec_valid <= start;
         wb_valid  <= start & pmove;
         idx_err   <= start & out_of_win;
         if (start) begin
            idx_addr <= idx_ptr;
            gpr_addr <= gpr_ptr;
            idx_next <= idx_fwd;
            wb_addr  <= idx_rev;
            gpr_nx_d <= gpr_fwd;
         end
      end
   end

   // execute slot: general-register pointer write-back
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gpr_upd_valid <= 1'b0;
         gpr_next      <= '0;
      end else begin
         gpr_upd_valid <= dec_valid;
         if (dec_valid) gpr_next <= gpr_nx_d;
      end
   end

   logic unused_ok;
   assign unused_ok = ^gpr_rev_unused;
endmodule

// File: rtl/agu_dual_ptr_chk.sv
module agu_dual_ptr_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          pmove,
   input logic [AW-1:0] idx_ptr,
   input logic [AW-1:0] gpr_ptr,
   input logic [2:0]    idx_mode,
   input logic          dec_valid,
   input logic [AW-1:0] idx_addr,
   input logic [AW-1:0] gpr_addr,
   input logic [AW-1:0] idx_next,
   input logic          wb_valid,
   input logic          idx_err,
   input logic          gpr_upd_valid
);
   AST_DEC_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> dec_valid); // R2
   AST_IDX_PREMOD: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> idx_addr == $past(idx_ptr)); // R2
   AST_GPR_PREMOD: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> gpr_addr == $past(gpr_ptr)); // R2
   AST_KEEP_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && idx_mode == 3'd0) |=> idx_next == idx_addr); // R3
   AST_WB_NEEDS_PMOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !pmove) |=> !wb_valid); // R6
   AST_WB_WITH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> dec_valid); // R6
   AST_ERR_WITH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      idx_err |-> dec_valid); // R7
   AST_GPR_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> gpr_upd_valid); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (!dec_valid && $stable(idx_addr) && $stable(idx_next))); // R9
endmodule

bind agu_dual_ptr agu_dual_ptr_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .pmove(pmove),
   .idx_ptr(idx_ptr), .gpr_ptr(gpr_ptr), .idx_mode(idx_mode),
   .dec_valid(dec_valid), .idx_addr(idx_addr), .gpr_addr(gpr_addr),
   .idx_next(idx_next), .wb_valid(wb_valid), .idx_err(idx_err),
   .gpr_upd_valid(gpr_upd_valid)
);

// File: tb/sim_agu_dual_ptr.sv
`timescale 1ns/1ps
module sim_agu_dual_ptr;
   localparam int AW = 16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, pmove = 1'b0, idx_qsel = 1'b0, gpr_qsel = 1'b0;
   logic [AW-1:0] idx_ptr = '0, gpr_ptr = '0;
   logic [2:0] idx_mode = '0, gpr_mode = '0;
   logic [AW-1:0] qx0 = 16'h0010, qx1 = 16'h0F02, qr0 = 16'h0102, qr1 = 16'h8000;
   logic dec_valid, wb_valid, idx_err, gpr_upd_valid;
   logic [AW-1:0] idx_addr, gpr_addr, idx_next, wb_addr, gpr_next;

   int n_vec = 0, n_bad = 0;

   always #2.5 clk = ~clk;

   agu_dual_ptr u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pmove(pmove),
      .idx_ptr(idx_ptr), .idx_mode(idx_mode), .idx_qsel(idx_qsel),
      .gpr_ptr(gpr_ptr), .gpr_mode(gpr_mode), .gpr_qsel(gpr_qsel),
      .qx0(qx0), .qx1(qx1), .qr0(qr0), .qr1(qr1),
      .dec_valid(dec_valid), .idx_addr(idx_addr), .gpr_addr(gpr_addr),
      .idx_next(idx_next), .wb_valid(wb_valid), .wb_addr(wb_addr),
      .idx_err(idx_err), .gpr_upd_valid(gpr_upd_valid), .gpr_next(gpr_next)
   );

   function automatic logic [AW-1:0] mod_fwd(logic [AW-1:0] p, logic [2:0] m, logic [AW-1:0] q);
      case (m)
         3'd1: return p + 16'd2;
         3'd2: return p - 16'd2;
         3'd3: return p + q;
         3'd4: return p - q;
         default: return p;
      endcase
   endfunction

   function automatic logic [AW-1:0] mod_rev(logic [AW-1:0] p, logic [2:0] m, logic [AW-1:0] q);
      case (m)
         3'd1: return p - 16'd2;
         3'd2: return p + 16'd2;
         3'd3: return p - q;
         3'd4: return p + q;
         default: return p;
      endcase
   endfunction

   task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run_vec(logic [AW-1:0] ip, logic [2:0] im, logic iq,
                          logic [AW-1:0] gp, logic [2:0] gm, logic gq, logic pm);
      logic [AW-1:0] qx, qr;
      logic out;
      qx  = iq ? qx1 : qx0;
      qr  = gq ? qr1 : qr0;
      out = (ip < 16'hF600) || (ip > 16'hF9FF);
      @(negedge clk);
      idx_ptr = ip; idx_mode = im; idx_qsel = iq;
      gpr_ptr = gp; gpr_mode = gm; gpr_qsel = gq; pmove = pm; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R2 dec_valid", {15'd0, dec_valid}, 16'd1);
      chk("R2 idx_addr", idx_addr, ip);
      chk("R2 gpr_addr", gpr_addr, gp);
      chk(im > 3'd4 ? "R5 idx_next" : "R3 idx_next", idx_next, mod_fwd(ip, im, qx));
      chk("R6 wb_valid", {15'd0, wb_valid}, {15'd0, pm});
      chk("R6 wb_addr", wb_addr, mod_rev(ip, im, qx));
      chk("R7 idx_err", {15'd0, idx_err}, {15'd0, out});
      // scramble inputs while idle: must have no effect (R9)
      idx_ptr = ~ip; gpr_ptr = ~gp; idx_mode = 3'd1;
      @(negedge clk);
      chk("R8 gpr_upd_valid", {15'd0, gpr_upd_valid}, 16'd1);
      chk(gm > 3'd4 ? "R5 gpr_next" : "R4 gpr_next", gpr_next, mod_fwd(gp, gm, qr));
      chk("R9 dec_valid low", {15'd0, dec_valid}, 16'd0);
      chk("R9 idx_addr held", idx_addr, ip);
      chk("R9 idx_next held", idx_next, mod_fwd(ip, im, qx));
      chk("R9 wb_addr held", wb_addr, mod_rev(ip, im, qx));
      chk("R9 gpr_addr held", gpr_addr, gp);
   endtask

   initial begin
      logic [AW-1:0] ptrs [6];
      ptrs[0] = 16'h0000; ptrs[1] = 16'hFFFE; ptrs[2] = 16'hF600;
      ptrs[3] = 16'hF9FE; ptrs[4] = 16'hFA00; ptrs[5] = 16'hF5FE;
      repeat (3) @(negedge clk);
      chk("R1 dec_valid", {15'd0, dec_valid}, 16'd0);
      chk("R1 wb_valid", {15'd0, wb_valid}, 16'd0);
      chk("R1 idx_err", {15'd0, idx_err}, 16'd0);
      chk("R1 gpr_upd_valid", {15'd0, gpr_upd_valid}, 16'd0);
      chk("R1 idx_addr", idx_addr, 16'h0000);
      chk("R1 gpr_next", gpr_next, 16'h0000);
      chk("R1 wb_addr", wb_addr, 16'h0000);
      rst_n = 1'b1;
      for (int m = 0; m < 8; m++)
         for (int p = 0; p < 6; p++)
            for (int s = 0; s < 4; s++)
               run_vec(ptrs[p], 3'(m), s[0], ptrs[5-p] ^ 16'h0100,
                       3'((m + 3) % 8), s[1], s[0] ^ s[1]);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #500000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule